// File: doc/BRIEF.md
# Dual-Ratio Clock Divider

This block derives two divided clocks from one input clock. The fast output runs at half the input rate. The slow output runs at a quarter or a sixth of the input rate, and a mode input picks the ratio. Both outputs come from one counter clocked by the input clock, so every rising edge of the slow output falls on a rising edge of the fast output.

A one-cycle marker flags each input cycle in which both outputs have just risen together, so downstream logic can find a common phase. An active-low run request pauses or resumes division. It is captured on the falling input edge, so division can only start or stop between two rising edges and never cuts a pulse short. An active-high master reset clears everything at once. All instances that share a clock line up with each other once they are reset together.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: While division is enabled, `q_half` inverts on every rising edge of `clk_in`, giving a period of 2 input cycles.
- R2: With the active mode 0 (`sel_hi` low), `q_slow` is high for 2 input cycles and low for 2.
- R3: With the active mode 1 (`sel_hi` high), `q_slow` is high for 3 input cycles and low for 3.
- R4: Every rising edge of `q_slow` happens at the same clock edge as a rising edge of `q_half`.
- R5: When the captured value of `en_n` is 1, `q_half`, `q_slow` keep their values and `mark` stays 0.
- R6: `en_n` is sampled only on the falling edge of `clk_in`. A change made while the clock is low first acts at the second rising edge that follows. A change made while the clock is high acts at the next rising edge.
- R7: While `rst` is 1, `q_half`, `q_slow` and `mark` are 0 at once, without waiting for a clock edge. The enable capture resets to the disabled state, so a rising edge that comes before the first falling edge after release does not advance.
- R8: `mark` is 1 for exactly one input cycle, and only in the cycle that starts at a common rising edge of `q_half` and `q_slow`.
- R9: A change of `sel_hi` takes effect only at the next common rising edge. The slow period in progress finishes with its old high and low lengths.
- R10: The first advancing edge after reset raises `q_half` and `q_slow` together and sets `mark`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock; all dividers advance on its rising edge |
| rst | input | 1 | Master reset, active high, asynchronous assertion |
| en_n | input | 1 | Run request, active low, captured on the falling edge |
| sel_hi | input | 1 | Slow ratio select: 0 divides by 4, 1 divides by 6 |
| q_half | output | 1 | Input clock divided by 2 |
| q_slow | output | 1 | Input clock divided by 4 or 6 |
| mark | output | 1 | One-cycle marker of a common rising edge |

## Verification
A mode change and a common rising edge can fall on the same clock edge. The mode switch itself happens at the common rise, so the bench changes `sel_hi` just after a common rise and measures the high and low lengths of the next two slow periods: old lengths first, then new ones. A pause or resume can also coincide with a common rise. The bench toggles `en_n` on both clock phases around wrap points, and a reference scoreboard judges `mark` and both outputs edge by edge.

// File: rtl/cdv_pkg.sv
package cdv_pkg;
  typedef enum logic {
    RATIO_LO = 1'b0,
    RATIO_HI = 1'b1
  } ratio_e;
endpackage

// File: rtl/cdv_en_capture.sv
module cdv_en_capture (
  input  logic clk,
  input  logic rst,
  input  logic en_n,
  output logic run
);
  // Falling-edge capture: run only changes while the clock is low.
  always_ff @(negedge clk or posedge rst) begin
    if (rst) run <= 1'b0;
    else     run <= ~en_n;
  end
endmodule

// File: rtl/cdv_phase_ctr.sv
module cdv_phase_ctr
  import cdv_pkg::*;
#(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 6,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sel,
  output logic [CNT_W-1:0] cnt_nx,
  output logic [CNT_W-1:0] half_nx,
  output logic             wrap_nx
);
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(DIV_LO - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(DIV_HI - 1);
  localparam logic [CNT_W-1:0] HALF_LO = CNT_W'(DIV_LO / 2);
  localparam logic [CNT_W-1:0] HALF_HI = CNT_W'(DIV_HI / 2);

  logic [CNT_W-1:0] cnt;
  ratio_e           mode;
  ratio_e           mode_nx;
  logic [CNT_W-1:0] last;

  always_comb begin
    last    = (mode == RATIO_HI) ? LAST_HI : LAST_LO;
    wrap_nx = run && (cnt == last);
    if (!run)         cnt_nx = cnt;
    else if (wrap_nx) cnt_nx = '0;
    else              cnt_nx = cnt + CNT_W'(1);
    mode_nx = wrap_nx ? ratio_e'(sel) : mode;
    half_nx = (mode_nx == RATIO_HI) ? HALF_HI : HALF_LO;
  end

  // Reset parks the counter on the last phase of the low ratio so that
  // the decoded outputs are low and the first advance is a common rise.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt  <= LAST_LO;
      mode <= RATIO_LO;
    end else begin
      cnt  <= cnt_nx;
      mode <= mode_nx;
    end
  end

  // R9: the ratio may only switch as the counter restarts its period
  assert_mode_at_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode) |-> (cnt == '0));
endmodule

// File: rtl/cdv_out_stage.sv
module cdv_out_stage #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt_nx,
  input  logic [CNT_W-1:0] half_nx,
  input  logic             wrap_nx,
  output logic             q_half,
  output logic             q_slow,
  output logic             mark
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      q_half <= 1'b0;
      q_slow <= 1'b0;
      mark   <= 1'b0;
    end else begin
      mark <= wrap_nx;
      if (run) begin
        q_half <= ~cnt_nx[0];
        q_slow <= (cnt_nx < half_nx);
      end
    end
  end

  // R1: each enabled edge inverts the fast output
  assert_toggle_R1: assert property (@(posedge clk) disable iff (rst)
    run |=> (q_half != $past(q_half)));
  // R5: a paused divider keeps both outputs
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(q_half) && $stable(q_slow) && !mark));
  // R4: slow rises only together with the fast output
  assert_slow_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(q_slow) |-> $rose(q_half));
  // R8: marker sits on a common rise and lasts one cycle
  assert_mark_coincident_R8: assert property (@(posedge clk) disable iff (rst)
    mark |-> ($rose(q_half) && $rose(q_slow)));
  assert_mark_single_R8: assert property (@(posedge clk) disable iff (rst)
    mark |=> !mark);
endmodule

// File: rtl/dual_ratio_clkdiv.sv
module dual_ratio_clkdiv #(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 6
) (
  input  logic clk_in,
  input  logic rst,
  input  logic en_n,
  input  logic sel_hi,
  output logic q_half,
  output logic q_slow,
  output logic mark
);
  localparam int DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int CNT_W   = $clog2(DIV_MAX);

  logic             run;
  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W-1:0] half_nx;
  logic             wrap_nx;

  cdv_en_capture u_en (
    .clk  (clk_in),
    .rst  (rst),
    .en_n (en_n),
    .run  (run)
  );

  cdv_phase_ctr #(
    .DIV_LO (DIV_LO),
    .DIV_HI (DIV_HI),
    .CNT_W  (CNT_W)
  ) u_ctr (
    .clk     (clk_in),
    .rst     (rst),
    .run     (run),
    .sel     (sel_hi),
    .cnt_nx  (cnt_nx),
    .half_nx (half_nx),
    .wrap_nx (wrap_nx)
  );

  cdv_out_stage #(
    .CNT_W (CNT_W)
  ) u_out (
    .clk     (clk_in),
    .rst     (rst),
    .run     (run),
    .cnt_nx  (cnt_nx),
    .half_nx (half_nx),
    .wrap_nx (wrap_nx),
    .q_half  (q_half),
    .q_slow  (q_slow),
    .mark    (mark)
  );

  // R7: reset holds every output low at each edge it covers
  assert_reset_clear_R7: assert property (@(posedge clk_in)
    rst |-> (!q_half && !q_slow && !mark));
endmodule

// File: tb/dual_ratio_clkdiv_tb_top.sv
module dual_ratio_clkdiv_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_T     = CLK_PERIOD / 2;

  logic clk_in = 1'b0;
  logic rst    = 1'b1;
  logic en_n   = 1'b0;
  logic sel_hi = 1'b0;
  logic q_half, q_slow, mark;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  dual_ratio_clkdiv dut_i (
    .clk_in (clk_in),
    .rst    (rst),
    .en_n   (en_n),
    .sel_hi (sel_hi),
    .q_half (q_half),
    .q_slow (q_slow),
    .mark   (mark)
  );

  always #HALF_T clk_in = ~clk_in;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model and scoreboard queue
  typedef struct packed { bit h; bit s; bit m; } exp_t;
  exp_t sb_q[$];
  bit m_run  = 1'b0;
  int m_pos  = 3;
  bit m_mode = 1'b0;
  exp_t m_out = '0;
  bit prev_h = 1'b0, prev_s = 1'b0;

  always @(negedge clk_in) begin
    if (rst) m_run = 1'b0;
    else     m_run = !en_n;
  end

  // driver side: predict the output of each rising edge and queue it
  always @(posedge clk_in) begin
    if (rst) begin
      m_run = 1'b0; m_pos = 3; m_mode = 1'b0; m_out = '0;
    end else begin
      m_out.m = 1'b0;
      if (m_run) begin
        m_pos++;
        if (m_pos >= (m_mode ? 6 : 4)) begin
          m_pos  = 0;
          m_mode = sel_hi;
        end
        m_out.h = (m_pos % 2 == 0);
        m_out.s = (m_pos < (m_mode ? 3 : 2));
        m_out.m = (m_pos == 0);
      end
    end
    sb_q.push_back(m_out);
  end

  // monitor side: pop and compare one cycle's outputs
  always @(posedge clk_in) begin
    exp_t e;
    #1;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      chk("R1 q_half", q_half, e.h);
      chk("R2 R3 R9 q_slow", q_slow, e.s);
      chk("R8 mark", mark, e.m);
      if (q_slow && !prev_s) chk("R4 q_half rises with q_slow", q_half && !prev_h, 1);
    end
    prev_h = q_half;
    prev_s = q_slow;
  end

  task automatic at_pos; @(posedge clk_in); #2; endtask
  task automatic at_neg; @(negedge clk_in); #2; endtask

  task automatic wait_rise;
    bit was;
    was = q_slow;
    forever begin
      at_pos();
      if (q_slow && !was) break;
      was = q_slow;
    end
  endtask

  // starts on a cycle where q_slow just rose, ends at the next rise
  task automatic count_period(output int hi, output int lo);
    hi = 0; lo = 0;
    while (q_slow)  begin hi++; at_pos(); end
    while (!q_slow) begin lo++; at_pos(); end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int hi, lo;
    bit h0, s0;
    logic [7:0] lfsr;
    repeat (3) at_pos();
    chk("R7 reset q_half", q_half, 0);
    chk("R7 reset q_slow", q_slow, 0);
    chk("R7 reset mark", mark, 0);

    // release while clock is low: next rising edge must not advance
    at_neg(); rst = 1'b0;
    at_pos(); chk("R7 no advance before first falling edge", q_half, 0);
    at_pos();
    chk("R10 q_half first rise", q_half, 1);
    chk("R10 q_slow first rise", q_slow, 1);
    chk("R10 mark first rise", mark, 1);

    wait_rise(); count_period(hi, lo);
    chk("R2 high length", hi, 2); chk("R2 low length", lo, 2);
    sel_hi = 1'b1;                       // just after a common rise
    count_period(hi, lo);
    chk("R9 old high kept", hi, 2); chk("R9 old low kept", lo, 2);
    count_period(hi, lo);
    chk("R3 high length", hi, 3); chk("R3 low length", lo, 3);
    count_period(hi, lo);
    chk("R3 second high", hi, 3);
    at_pos(); sel_hi = 1'b0;             // mid high phase
    wait_rise(); count_period(hi, lo);
    chk("R9 switch back high", hi, 2); chk("R9 switch back low", lo, 2);

    // pause requested while clock high: holds from the next rising edge
    en_n = 1'b1;
    at_pos(); h0 = q_half; s0 = q_slow;
    for (int i = 0; i < 4; i++) begin
      at_pos();
      chk("R5 q_half held", q_half, h0);
      chk("R5 q_slow held", q_slow, s0);
      chk("R5 mark low", mark, 0);
    end

    // resume requested while clock low: one more held edge, then advance
    at_neg(); en_n = 1'b0;
    at_pos(); chk("R6 late resume still held", q_half, h0);
    at_pos(); chk("R6 resume advances", q_half, !h0);
    at_neg(); en_n = 1'b1; h0 = q_half;
    at_pos(); chk("R6 late pause still advances", q_half, !h0);
    at_pos(); chk("R6 pause holds", q_half, !h0);
    at_pos(); en_n = 1'b0;
    repeat (5) at_pos();

    // asynchronous reset in the low phase, checked before any edge
    at_neg(); rst = 1'b1; #1;
    chk("R7 async q_half", q_half, 0);
    chk("R7 async q_slow", q_slow, 0);
    chk("R7 async mark", mark, 0);
    repeat (2) at_pos();
    rst = 1'b0;                          // released while clock high
    at_pos();
    chk("R10 rise after reset q_half", q_half, 1);
    chk("R10 rise after reset q_slow", q_slow, 1);
    chk("R10 rise after reset mark", mark, 1);

    // mixed traffic: pauses and mode changes on both clock phases
    lfsr = 8'hA5;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr[0]) at_pos(); else at_neg();
      if (lfsr[7:5] == 3'b000) en_n = ~en_n;
      if (lfsr[4:2] == 3'b101) sel_hi = ~sel_hi;
      if (i > 290) en_n = 1'b0;
    end
    repeat (4) at_pos();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule